// File: doc/BRIEF.md
# Fixed-Point PI Duty-Cycle Controller

This block closes the digital voltage loop of a switched-mode converter. At each sample strobe it takes one signed Q15 error word and advances a duty-cycle command by an incremental PI law. It emits an unsigned duty code one clock later for a downstream PWM generator. The two loop gains are larger than one. They are held as Q15 words scaled down by 32, and the product sum is shifted left by five bits to restore the true gain.

The stored duty state is clamped to the physical range of 0% to 100% before it is written back, so the integrator cannot wind up. The state carries thirty fractional bits, and only the code sent to the PWM is truncated to the output width. A second duty request from a current-limit loop arrives on its own input. The smaller of the two requests is issued, so no mode switching is needed. The two gains can be rewritten through a small write port.

Top module: `pi_duty_ctrl`

## Requirements
- R1: For each sample the state is updated as s(k) = s(k-1) + 32·(b0·e(k) − b1·e(k-1)). Here e is the signed Q15 error, b0 and b1 are the signed Q15 gain words, and s has 30 fractional bits, so 1.0 equals 2^30.
- R2: After reset, b0 is 0x6400 (25/32) and b1 is 0x5C00 (23/32). The first sample after reset therefore yields 25·e(0), clamped.
- R3: A sum above full scale (2^30) is stored as full scale. Full scale is issued as the all-ones duty code (4095 with 12 bits).
- R4: A negative sum is stored as zero and gives duty code 0.
- R5: The clamped value, not the raw sum, is kept as s(k-1) for the next sample. The state never leaves the range 0..2^30.
- R6: The state keeps all 30 fractional bits. The duty code is s[29:18], which truncates toward zero, so increments smaller than one code step still accumulate.
- R7: The issued duty is the minimum of the voltage-loop code and the current-limit input ilim_duty sampled with the same strobe. The current limit never changes the stored state.
- R8: duty_valid is high for exactly the one cycle after each sample_valid cycle. duty_out changes only in that cycle and holds otherwise.
- R9: A write with coef_we sets b0 when coef_sel is 0 and b1 when coef_sel is 1. A sample in the same cycle as a write still uses the old gains.
- R10: Synchronous active-high reset clears the state, the previous error, duty_out and duty_valid, and reloads the default gains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-cycle strobe marking a new error sample |
| err_in | input | 16 | Signed Q15 error sample |
| ilim_duty | input | 12 | Current-limit duty request, unsigned code |
| coef_we | input | 1 | Gain write enable |
| coef_sel | input | 1 | Gain select: 0 = gain on e(k), 1 = gain on e(k-1) |
| coef_wdata | input | 16 | Signed Q15 gain word to write |
| duty_out | output | 12 | Issued duty code |
| duty_valid | output | 1 | High the cycle after a sample is taken |

## Verification
The bench first drives the loop into the upper clamp and then applies a smaller error. A design that wrote back the unclamped sum would stay pinned at 4095 instead of falling to the predicted code. Runs of one-LSB errors catch a state truncated to PWM resolution, because that design would never move off its first code. Current-limit steps followed by a released limit show whether the limit leaked into the state. Gain writes in the same cycle as a sample, together with resets after gain writes, show whether the new gains were applied one sample early or survived reset.

// File: rtl/pi_duty_pkg.sv
`timescale 1ns/1ps
package pi_duty_pkg;

  // Which gain word a write targets.
  typedef enum logic {
    GAIN_CUR  = 1'b0,
    GAIN_PREV = 1'b1
  } gain_sel_e;

endpackage

// File: rtl/pi_coef_regs.sv
`timescale 1ns/1ps
module pi_coef_regs #(
  parameter int COEF_W = 16,
  parameter logic [COEF_W-1:0] RST_CUR  = 16'h6400,
  parameter logic [COEF_W-1:0] RST_PREV = 16'h5C00
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  pi_duty_pkg::gain_sel_e   sel,
  input  logic [COEF_W-1:0]        wdata,
  output logic signed [COEF_W-1:0] gain_cur,
  output logic signed [COEF_W-1:0] gain_prev
);

  localparam int N_GAIN = 2;

  logic [COEF_W-1:0] gain_q [N_GAIN];

  for (genvar g = 0; g < N_GAIN; g++) begin : g_gain
    localparam logic [COEF_W-1:0] RST_VAL = (g == 0) ? RST_CUR : RST_PREV;
    always_ff @(posedge clk) begin
      if (rst) begin
        gain_q[g] <= RST_VAL;
      end else if (we && (sel == pi_duty_pkg::gain_sel_e'(g))) begin
        gain_q[g] <= wdata;
      end
    end
  end

  assign gain_cur  = $signed(gain_q[0]);
  assign gain_prev = $signed(gain_q[1]);

endmodule

// File: rtl/pi_mac.sv
`timescale 1ns/1ps
module pi_mac #(
  parameter int ERR_W      = 16,
  parameter int COEF_W     = 16,
  parameter int STATE_W    = 31,
  parameter int GAIN_SHIFT = 5,
  parameter int ACC_W      = 40
) (
  input  logic signed [ERR_W-1:0]  err_cur,
  input  logic signed [ERR_W-1:0]  err_prev,
  input  logic signed [COEF_W-1:0] gain_cur,
  input  logic signed [COEF_W-1:0] gain_prev,
  input  logic [STATE_W-1:0]       state,
  output logic signed [ACC_W-1:0]  acc
);

  localparam int PROD_W = ERR_W + COEF_W;

  logic signed [PROD_W-1:0] prod_cur;
  logic signed [PROD_W-1:0] prod_prev;
  logic signed [ACC_W-1:0]  prod_cur_x;
  logic signed [ACC_W-1:0]  prod_prev_x;
  logic signed [ACC_W-1:0]  delta;
  logic signed [ACC_W-1:0]  state_x;

  always_comb begin
    prod_cur    = err_cur * gain_cur;
    prod_prev   = err_prev * gain_prev;
    prod_cur_x  = {{(ACC_W-PROD_W){prod_cur[PROD_W-1]}}, prod_cur};
    prod_prev_x = {{(ACC_W-PROD_W){prod_prev[PROD_W-1]}}, prod_prev};
    // Restore the true gain of the pre-scaled words.
    delta       = (prod_cur_x - prod_prev_x) <<< GAIN_SHIFT;
    state_x     = {{(ACC_W-STATE_W){1'b0}}, state};
    acc         = state_x + delta;
  end

endmodule

// File: rtl/pi_sat.sv
`timescale 1ns/1ps
module pi_sat #(
  parameter int ACC_W   = 40,
  parameter int STATE_W = 31,
  parameter int FRAC_W  = 30,
  parameter int DUTY_W  = 12
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic [STATE_W-1:0]      state_next,
  output logic [DUTY_W-1:0]       duty_code
);

  localparam logic signed [ACC_W-1:0] FULL_ACC =
    {{(ACC_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
  localparam logic [STATE_W-1:0] FULL_STATE =
    {{(STATE_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

  always_comb begin
    if (acc[ACC_W-1]) begin
      state_next = '0;
    end else if (acc > FULL_ACC) begin
      state_next = FULL_STATE;
    end else begin
      state_next = acc[STATE_W-1:0];
    end
    if (state_next[FRAC_W]) begin
      duty_code = '1;
    end else begin
      duty_code = state_next[FRAC_W-1 -: DUTY_W];
    end
  end

endmodule

// File: rtl/pi_duty_ctrl.sv
`timescale 1ns/1ps
module pi_duty_ctrl #(
  parameter int ERR_W      = 16,
  parameter int COEF_W     = 16,
  parameter int DUTY_W     = 12,
  parameter int GAIN_SHIFT = 5,
  parameter logic [COEF_W-1:0] GAIN_CUR_RST  = 16'h6400,
  parameter logic [COEF_W-1:0] GAIN_PREV_RST = 16'h5C00
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sample_valid,
  input  logic signed [ERR_W-1:0] err_in,
  input  logic [DUTY_W-1:0]       ilim_duty,
  input  logic                    coef_we,
  input  logic                    coef_sel,
  input  logic [COEF_W-1:0]       coef_wdata,
  output logic [DUTY_W-1:0]       duty_out,
  output logic                    duty_valid
);

  localparam int FRAC_W  = (ERR_W - 1) + (COEF_W - 1);
  localparam int STATE_W = FRAC_W + 1;
  localparam int ACC_W   = ERR_W + COEF_W + GAIN_SHIFT + 3;

  logic signed [COEF_W-1:0] gain_cur;
  logic signed [COEF_W-1:0] gain_prev;
  logic signed [ERR_W-1:0]  err_prev_q;
  logic [STATE_W-1:0]       state_q;
  logic signed [ACC_W-1:0]  acc;
  logic [STATE_W-1:0]       state_next;
  logic [DUTY_W-1:0]        vloop_code;
  logic [DUTY_W-1:0]        duty_sel;

  pi_coef_regs #(
    .COEF_W  (COEF_W),
    .RST_CUR (GAIN_CUR_RST),
    .RST_PREV(GAIN_PREV_RST)
  ) u_coef (
    .clk      (clk),
    .rst      (rst),
    .we       (coef_we),
    .sel      (pi_duty_pkg::gain_sel_e'(coef_sel)),
    .wdata    (coef_wdata),
    .gain_cur (gain_cur),
    .gain_prev(gain_prev)
  );

  pi_mac #(
    .ERR_W     (ERR_W),
    .COEF_W    (COEF_W),
    .STATE_W   (STATE_W),
    .GAIN_SHIFT(GAIN_SHIFT),
    .ACC_W     (ACC_W)
  ) u_mac (
    .err_cur  (err_in),
    .err_prev (err_prev_q),
    .gain_cur (gain_cur),
    .gain_prev(gain_prev),
    .state    (state_q),
    .acc      (acc)
  );

  pi_sat #(
    .ACC_W  (ACC_W),
    .STATE_W(STATE_W),
    .FRAC_W (FRAC_W),
    .DUTY_W (DUTY_W)
  ) u_sat (
    .acc       (acc),
    .state_next(state_next),
    .duty_code (vloop_code)
  );

  // Smaller request wins; the state keeps the voltage-loop value only.
  assign duty_sel = (ilim_duty < vloop_code) ? ilim_duty : vloop_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= '0;
      err_prev_q <= '0;
      duty_out   <= '0;
      duty_valid <= 1'b0;
    end else begin
      duty_valid <= sample_valid;
      if (sample_valid) begin
        state_q    <= state_next;
        err_prev_q <= err_in;
        duty_out   <= duty_sel;
      end
    end
  end

endmodule

// File: rtl/pi_duty_chk.sv
`timescale 1ns/1ps
module pi_duty_chk #(
  parameter int DUTY_W  = 12,
  parameter int STATE_W = 31,
  parameter int FRAC_W  = 30
) (
  input logic               clk,
  input logic               rst,
  input logic               sample_valid,
  input logic [DUTY_W-1:0]  ilim_duty,
  input logic [DUTY_W-1:0]  duty_out,
  input logic               duty_valid,
  input logic [STATE_W-1:0] state_q
);

  localparam logic [STATE_W-1:0] FULL_STATE =
    {{(STATE_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

  p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> duty_valid);

  p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> !duty_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> $stable(duty_out));

  p_min_sel_r7: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> (duty_out <= $past(ilim_duty)));

  p_state_range_r5: assert property (@(posedge clk) disable iff (rst)
    state_q <= FULL_STATE);

  p_state_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> $stable(state_q));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (duty_out == '0 && !duty_valid && state_q == '0));

endmodule

bind pi_duty_ctrl pi_duty_chk #(
  .DUTY_W (DUTY_W),
  .STATE_W(STATE_W),
  .FRAC_W (FRAC_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sample_valid(sample_valid),
  .ilim_duty   (ilim_duty),
  .duty_out    (duty_out),
  .duty_valid  (duty_valid),
  .state_q     (state_q)
);

// File: tb/test_pi_duty_ctrl.sv
`timescale 1ns/1ps
module test_pi_duty_ctrl;

  localparam longint FULL = 64'sd1 << 30;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               sample_valid = 1'b0;
  logic signed [15:0] err_in = '0;
  logic [11:0]        ilim_duty = 12'hFFF;
  logic               coef_we = 1'b0;
  logic               coef_sel = 1'b0;
  logic [15:0]        coef_wdata = '0;
  logic [11:0]        duty_out;
  logic               duty_valid;

  int     n_checks = 0;
  int     n_errors = 0;
  bit     done = 1'b0;
  longint m_state;
  int     m_eprev;
  int     m_b0;
  int     m_b1;

  always #10 clk = ~clk;

  pi_duty_ctrl i_pi_duty_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sample_valid(sample_valid),
    .err_in      (err_in),
    .ilim_duty   (ilim_duty),
    .coef_we     (coef_we),
    .coef_sel    (coef_sel),
    .coef_wdata  (coef_wdata),
    .duty_out    (duty_out),
    .duty_valid  (duty_valid)
  );

  function automatic longint next_state(longint s, int e, int ep, int b0, int b1);
    longint acc;
    acc = s + (longint'(b0) * e - longint'(b1) * ep) * 32;
    if (acc < 0) return 0;
    if (acc > FULL) return FULL;
    return acc;
  endfunction

  function automatic int code_of(longint s);
    if (s >= FULL) return 4095;
    return int'(s >>> 18);
  endfunction

  task automatic check(string req, int actual, int expected);
    n_checks++;
    if (actual != expected) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_state = 0;
    m_eprev = 0;
    m_b0 = 16'sh6400;
    m_b1 = 16'sh5C00;
  endtask

  // Drive one sample and check the result the cycle after.
  task automatic do_sample(string req, int e, int ilim);
    int exp_code;
    @(negedge clk);
    sample_valid = 1'b1;
    err_in = 16'(e);
    ilim_duty = 12'(ilim);
    @(negedge clk);
    sample_valid = 1'b0;
    m_state = next_state(m_state, e, m_eprev, m_b0, m_b1);
    m_eprev = e;
    exp_code = code_of(m_state);
    if (ilim < exp_code) exp_code = ilim;
    check({req, " valid"}, int'(duty_valid), 1);
    check({req, " duty"}, int'(duty_out), exp_code);
  endtask

  task automatic write_gain(bit sel, int val, bit with_sample, int e);
    @(negedge clk);
    coef_we = 1'b1;
    coef_sel = sel;
    coef_wdata = 16'(val);
    sample_valid = with_sample;
    err_in = 16'(e);
    ilim_duty = 12'hFFF;
    @(negedge clk);
    coef_we = 1'b0;
    sample_valid = 1'b0;
    if (with_sample) begin
      m_state = next_state(m_state, e, m_eprev, m_b0, m_b1);
      m_eprev = e;
      check("R9 old gains used in write cycle", int'(duty_out), code_of(m_state));
    end
    if (sel) m_b1 = int'($signed(16'(val)));
    else     m_b0 = int'($signed(16'(val)));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R10: reset state at the ports
    check("R10 reset duty", int'(duty_out), 0);
    check("R10 reset valid", int'(duty_valid), 0);

    // R1 R2: first sample gives 25*e(0), then the incremental step
    do_sample("R2 first sample", 100, 4095);
    @(negedge clk);
    check("R8 valid single cycle", int'(duty_valid), 0);
    check("R8 duty held", int'(duty_out), 312);
    do_sample("R1 second sample", 100, 4095);
    do_sample("R1 error step down", -40, 4095);

    // R6: sub-LSB increments accumulate in the state
    do_reset();
    for (int i = 0; i < 12; i++) do_sample("R6 fine accumulation", 1, 4095);

    // R3 then R5: saturate high, then a smaller error must pull back at once
    do_reset();
    do_sample("R3 clamp high", 2000, 4095);
    check("R3 full scale code", int'(duty_out), 4095);
    do_sample("R3 stay high", 2000, 4095);
    do_sample("R3 stay high", 2000, 4095);
    do_sample("R5 anti-windup release", 1000, 4095);
    check("R5 expected release code", int'(duty_out), 1471);

    // R4: negative sum clamps to zero, then recovery from zero
    do_reset();
    do_sample("R4 clamp low", -500, 4095);
    check("R4 zero code", int'(duty_out), 0);
    do_sample("R4 recover from zero", 10, 4095);

    // R7: current limit wins, then release shows untouched state
    do_reset();
    do_sample("R7 limit active", 200, 100);
    check("R7 limited code", int'(duty_out), 100);
    do_sample("R7 limit released", 200, 4095);
    do_sample("R7 limit above vloop", 0, 4000);

    // R9: gain writes, same-cycle sample keeps old gains
    do_reset();
    write_gain(1'b0, 16'h2000, 1'b1, 300);
    write_gain(1'b1, 16'h0000, 1'b0, 0);
    do_sample("R9 new gain cur", 300, 4095);
    do_sample("R9 new gain prev zero", 50, 4095);
    // R10 R2: reset restores default gains
    do_reset();
    do_sample("R10 default gains after reset", 100, 4095);
    check("R2 default gain code", int'(duty_out), 312);

    // Random mix
    do_reset();
    for (int i = 0; i < 400; i++) begin
      int e;
      int lim;
      e = int'($urandom_range(6000)) - 3000;
      lim = ($urandom_range(3) == 0) ? int'($urandom_range(4095)) : 4095;
      if ($urandom_range(19) == 0)
        write_gain(1'($urandom_range(1)), int'($urandom_range(32767)),
                   1'($urandom_range(1)), e);
      else
        do_sample("R1 random", e, lim);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule